// File: doc/BRIEF.md
# Buffered Timer Output Compare Channel

This block is one 16-bit output compare channel together with the 16-bit timer counter it watches. Software reaches it through an 8-bit register bus. The counter steps once for each pulse on a tick enable. It can run in three ways:
- free-running to 0xFFFF;
- restarting from zero when it matches the compare value;
- single-slope PWM, with an end point held in a separate limit register.

Each unblocked match of the counter against the compare value sets a sticky flag. The same match drives a waveform bit according to a 2-bit output action field.

Writes to the compare value are double-buffered only in PWM. In that mode a CPU write lands in a shadow register, and the compare value takes the shadow value when the counter rolls over to zero. This keeps every PWM period whole. In the other two modes the CPU writes the compare value directly.

All 16-bit registers are written high byte first, through one shared holding byte. Two more features help software start a waveform cleanly:
- A force strobe applies the output action without touching the flag or the counter.
- A CPU write to the counter hides the match on the tick that follows.

Top module: `oc_channel`

## Requirements
- R1: The counter rises by one on each cycle with `tick` high and holds when `tick` is low. It returns to zero after its end value. Mode field `ctrl[1:0]` selects the end value: 00 means 0xFFFF, 01 means the compare value, and 10 or 11 mean PWM with the limit register as end value. A counter write takes priority over a tick in the same cycle.
- R2: Registers are at addresses 0/1 (counter), 2/3 (compare) and 4/5 (limit), low byte at the even address. A write to any odd address only loads a shared holding byte. A write to the even address stores {holding byte, written byte} in one clock.
- R3: In PWM, compare writes go to a shadow register, and the active compare value takes the shadow value only when the counter rolls over to zero. In the other modes a write updates both the active compare value and the shadow together.
- R4: Reads return the live counter and the limit register. Compare reads return the shadow in PWM and the active value otherwise. Address 6 reads {4'b0, action, mode} and address 7 reads {7'b0, flag}.
- R5: On a tick with counter equal to compare and no blocking, `match_flag` is set on the next edge. Writing a byte with bit 0 set to address 7 clears the flag, and a set in the same cycle wins.
- R6: The output action field is `ctrl[3:2]`: 00 leaves `oc_out` unchanged, 01 toggles it on a match, 10 clears it and 11 sets it.
- R7: In PWM the counter rolling over to zero drives `oc_out` to 1 for action 10 and to 0 for action 11. This rollover takes priority over a match on the same tick.
- R8: Writing address 6 with bit 4 set and a non-PWM mode in the same byte updates `oc_out` using the action bits of that byte. The flag is not set and the counter does not change. The strobe bit reads back as 0.
- R9: After a counter write, the next tick (even if many cycles later) advances the counter but produces no match, no flag and no output change.
- R10: In the restart and PWM modes, if the counter is written with its end value, that end value is missed. The counter then runs on through 0xFFFF to zero.
- R11: Reset clears every register, the flag and `oc_out`. A change of mode alone leaves `oc_out` as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timer step enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| oc_out | output | 1 | Waveform output bit |
| match_flag | output | 1 | Sticky compare match flag |

## Verification
The assertions assume the following about the inputs:
- `tick` is sampled as a level on each clock.
- At most one register write happens per cycle.
- A counter write in a cycle overrides that cycle's tick.
- `ctrl` bits other than the mode, action and strobe are ignored.

The stimulus drives all inputs one time unit after the rising edge, so every value is stable at the next sampling edge. Every 16-bit write goes high byte first. Random phases keep counter, compare and limit values small, so matches, rollovers and blocked ticks happen often, and the bench still produces mode changes, flag clears and force strobes of every kind.

// File: rtl/oc_pkg.sv
// Shared definitions for the output compare channel: mode encoding,
// register addresses and control bit positions. Assumes an 8-bit bus
// with a 3-bit address.
package oc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        WG_FREE = 2'b00,
        WG_CTC  = 2'b01,
        WG_PWM  = 2'b10,
        WG_PWM2 = 2'b11
    } wg_e;

    localparam logic [1:0] ACT_NONE   = 2'b00;
    localparam logic [1:0] ACT_TOGGLE = 2'b01;
    localparam logic [1:0] ACT_CLEAR  = 2'b10;
    localparam logic [1:0] ACT_SET    = 2'b11;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd6;
    localparam logic [ADDR_W-1:0] A_FLAG   = 3'd7;

    localparam int FORCE_BIT = 4;

    // True for either PWM mode encoding
    function automatic logic is_pwm(input wg_e m);
        return m[1];
    endfunction

    // Next waveform level for a given action
    function automatic logic apply_act(input logic [1:0] act, input logic cur);
        case (act)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction
endpackage

// File: rtl/oc_regs.sv
// Byte-wide register file for the channel. It holds the shared holding
// byte, the active compare value, its shadow, the limit register and the
// control fields. Assumes at most one write per cycle and high-before-low
// ordering by software. Decodes the counter write, force strobe and flag clear.
module oc_regs
    import oc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              roll,
    input  logic              flag,
    output logic [CNT_W-1:0]  cmp,
    output logic [CNT_W-1:0]  lim,
    output wg_e               wgm,
    output logic [1:0]        act,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              force_stb,
    output logic [1:0]        force_act,
    output logic              flag_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [DATA_W-1:0] hold;
    logic [CNT_W-1:0]  shadow;
    logic [CNT_W-1:0]  commit;
    logic [CNT_W-1:0]  cmp_view;

    assign commit    = {hold, bus_wdata};
    assign cnt_wr    = bus_wr && (bus_addr == A_CNT_LO);
    assign cnt_wdata = commit;
    assign force_stb = bus_wr && (bus_addr == A_CTRL) && bus_wdata[FORCE_BIT]
                       && !is_pwm(wg_e'(bus_wdata[1:0]));
    assign force_act = bus_wdata[3:2];
    assign flag_clr  = bus_wr && (bus_addr == A_FLAG) && bus_wdata[0];
    assign cmp_view  = is_pwm(wgm) ? shadow : cmp;

    // Holding byte: loaded by any high-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (bus_wr && bus_addr[0])
            hold <= bus_wdata;
    end

    // Compare value and shadow: direct or buffered, reload on rollover
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp    <= '0;
            shadow <= '0;
        end else begin
            if (roll && is_pwm(wgm))
                cmp <= shadow;
            if (bus_wr && bus_addr == A_CMP_LO) begin
                shadow <= commit;
                if (!is_pwm(wgm))
                    cmp <= commit;
            end
        end
    end

    // Limit register and control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim <= '0;
            wgm <= WG_FREE;
            act <= ACT_NONE;
        end else if (bus_wr) begin
            if (bus_addr == A_LIM_LO)
                lim <= commit;
            if (bus_addr == A_CTRL) begin
                wgm <= wg_e'(bus_wdata[1:0]);
                act <= bus_wdata[3:2];
            end
        end
    end

    // Read multiplexer, no holding byte on the read path
    always_comb begin
        case (bus_addr)
            A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
            A_CMP_LO: bus_rdata = cmp_view[DATA_W-1:0];
            A_CMP_HI: bus_rdata = cmp_view[CNT_W-1:DATA_W];
            A_LIM_LO: bus_rdata = lim[DATA_W-1:0];
            A_LIM_HI: bus_rdata = lim[CNT_W-1:DATA_W];
            A_CTRL:   bus_rdata = DATA_W'({act, wgm});
            default:  bus_rdata = DATA_W'(flag);
        endcase
    end

    // In PWM the active compare value moves only at rollover (R3)
    p_buffered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(wgm) && !roll) |=> $stable(cmp));
endmodule

// File: rtl/oc_counter.sv
// Timer counter with end-value selection and one-tick match blocking after
// a CPU counter write. Assumes tick is a one-cycle enable. Produces the
// qualified tick for match checks and the rollover event.
module oc_counter
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  wg_e              wgm,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] cnt,
    output logic             eval,
    output logic             roll
);
    logic             blk;
    logic             end_hit;
    logic [CNT_W-1:0] end_val;

    // End value per mode
    always_comb begin
        case (wgm)
            WG_FREE: end_val = '1;
            WG_CTC:  end_val = cmp;
            default: end_val = lim;
        endcase
    end

    assign eval    = tick && !cnt_wr && !blk;
    assign end_hit = eval && (wgm != WG_FREE) && (cnt == end_val);
    assign roll    = tick && !cnt_wr && (end_hit || cnt == '1);

    // Counter: CPU load wins, else step or restart on tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt_wr)
            cnt <= cnt_wdata;
        else if (tick)
            cnt <= end_hit ? '0 : cnt + 1'b1;
    end

    // Blocking flag: armed by a counter write, spent by the next tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk <= 1'b0;
        else if (cnt_wr)
            blk <= 1'b1;
        else if (tick)
            blk <= 1'b0;
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !roll) |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));
    p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !eval);
endmodule

// File: rtl/oc_wave.sv
// Match detection, waveform output bit and sticky match flag. Assumes
// eval already excludes blocked ticks. The force strobe acts on the
// output only.
module oc_wave
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic             roll,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  wg_e              wgm,
    input  logic [1:0]       act,
    input  logic             force_stb,
    input  logic [1:0]       force_act,
    input  logic             flag_clr,
    output logic             oc_out,
    output logic             flag
);
    logic hit;

    assign hit = eval && (cnt == cmp);

    // Waveform bit: PWM rollover level, then match action, then force
    always_ff @(posedge clk) begin
        if (!rst_n)
            oc_out <= 1'b0;
        else if (roll && is_pwm(wgm) && act[1])
            oc_out <= (act == ACT_CLEAR);
        else if (hit)
            oc_out <= apply_act(act, oc_out);
        else if (force_stb)
            oc_out <= apply_act(force_act, oc_out);
    end

    // Sticky flag: a match sets it, a CPU write of one clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    p_flag_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !hit) |=> !flag);
    p_nc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE && !force_stb) |=> $stable(oc_out));
    p_force_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !eval && !flag) |=> !flag);
    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval && !force_stb && !roll) |=> $stable(oc_out));
endmodule

// File: rtl/oc_channel.sv
// Top of the output compare channel: register file, counter and waveform
// stage. Assumes a single clock domain and a tick enable already
// divided down from it.
module oc_channel
    import oc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              oc_out,
    output logic              match_flag
);
    logic [CNT_W-1:0] cnt, cmp, lim, cnt_wdata;
    logic             eval, roll, cnt_wr, force_stb, flag_clr;
    logic [1:0]       act, force_act;
    wg_e              wgm;

    oc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt(cnt), .roll(roll), .flag(match_flag),
        .cmp(cmp), .lim(lim), .wgm(wgm), .act(act), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .force_stb(force_stb), .force_act(force_act),
        .flag_clr(flag_clr), .bus_rdata(bus_rdata)
    );

    oc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .wgm(wgm), .cmp(cmp), .lim(lim),
        .cnt(cnt), .eval(eval), .roll(roll)
    );

    oc_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .eval(eval), .roll(roll), .cnt(cnt),
        .cmp(cmp), .wgm(wgm), .act(act), .force_stb(force_stb),
        .force_act(force_act), .flag_clr(flag_clr), .oc_out(oc_out),
        .flag(match_flag)
    );
endmodule

// File: tb/oc_channel_tb.sv
`timescale 1ns/1ps
module oc_channel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       oc_out, match_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    oc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .oc_out(oc_out), .match_flag(match_flag)
    );

    // Behavioural reference state
    int m_cnt, m_cmp, m_shd, m_lim, m_hold, m_mode, m_act;
    bit m_blk, m_oc, m_flag;

    function automatic int do_act(int a, bit cur);
        if (a == 1) return !cur;
        if (a == 2) return 0;
        if (a == 3) return 1;
        return cur;
    endfunction

    function automatic int model_read(int a);
        int cv;
        cv = (m_mode >= 2) ? m_shd : m_cmp;
        case (a)
            0: return m_cnt & 255;
            1: return m_cnt >> 8;
            2: return cv & 255;
            3: return cv >> 8;
            4: return m_lim & 255;
            5: return m_lim >> 8;
            6: return (m_act << 2) | m_mode;
            default: return m_flag;
        endcase
    endfunction

    // Reference model update on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_shd = 0; m_lim = 0; m_hold = 0;
            m_mode = 0; m_act = 0; m_blk = 0; m_oc = 0; m_flag = 0;
        end else begin
            int w, endv, nxt_cnt, nxt_cmp;
            bit cw, live, hit, endhit, rolled, pwm, frc;
            w = (m_hold << 8) | bus_wdata;
            pwm = (m_mode >= 2);
            endv = (m_mode == 0) ? 65535 : (m_mode == 1) ? m_cmp : m_lim;
            cw = bus_wr && bus_addr == 0;
            live = tick && !cw && !m_blk;
            hit = live && m_cnt == m_cmp;
            endhit = live && m_mode != 0 && m_cnt == endv;
            rolled = tick && !cw && (endhit || m_cnt == 65535);
            frc = bus_wr && bus_addr == 6 && bus_wdata[4] && !bus_wdata[1];
            nxt_cnt = cw ? w : tick ? (endhit ? 0 : (m_cnt + 1) & 65535) : m_cnt;
            if (rolled && pwm && m_act >= 2) m_oc = (m_act == 2);
            else if (hit) m_oc = do_act(m_act, m_oc);
            else if (frc) m_oc = do_act(int'(bus_wdata[3:2]), m_oc);
            if (hit) m_flag = 1;
            else if (bus_wr && bus_addr == 7 && bus_wdata[0]) m_flag = 0;
            nxt_cmp = (rolled && pwm) ? m_shd : m_cmp;
            if (bus_wr && bus_addr == 2) begin
                m_shd = w;
                if (!pwm) nxt_cmp = w;
            end
            m_cmp = nxt_cmp;
            if (cw) m_blk = 1; else if (tick) m_blk = 0;
            m_cnt = nxt_cnt;
            if (bus_wr && bus_addr == 4) m_lim = w;
            if (bus_wr && bus_addr == 6) begin
                m_mode = bus_wdata[1:0];
                m_act = bus_wdata[3:2];
            end
            if (bus_wr && bus_addr[0]) m_hold = bus_wdata;
        end
    end

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // Every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 R6 R7 R8 R11 oc_out", int'(oc_out), int'(m_oc));
            chk("R5 R8 R9 match_flag", int'(match_flag), int'(m_flag));
            chk("R1 R2 R4 R10 bus_rdata", int'(bus_rdata), model_read(int'(bus_addr)));
        end
    end

    task automatic step(bit t);
        @(posedge clk); #1;
        bus_wr = 0; tick = t;
    endtask

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a[2:0]; bus_wdata = d[7:0]; tick = 0;
    endtask

    task automatic wr16(int a, int v);
        wr(a + 1, v >> 8);
        wr(a, v & 255);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1);
    endtask

    task automatic rd16(int a, output int v);
        int lo;
        @(posedge clk); #1;
        bus_wr = 0; tick = 0; bus_addr = a[2:0];
        @(negedge clk); lo = bus_rdata;
        @(posedge clk); #1;
        bus_addr = a[2:0] + 3'd1;
        @(negedge clk); v = (int'(bus_rdata) << 8) | lo;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        bit saved;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R11 reset oc_out", int'(oc_out), 0);
        chk("R11 reset flag", int'(match_flag), 0);
        rd16(0, v); chk("R11 reset counter", v, 0);

        // R2: high byte alone does not commit
        wr(3, 8'h12);
        rd16(2, v); chk("R2 high byte only", v, 0);
        wr(2, 8'h34);
        rd16(2, v); chk("R2 committed pair", v, 16'h1234);

        // R1: free-running count, toggle action
        wr(6, 8'h04);
        wr16(0, 16'h1230);
        ticks(3);
        rd16(0, v); chk("R1 count after ticks", v, 16'h1233);
        ticks(2); step(0);
        @(negedge clk);
        chk("R5 flag on match", int'(match_flag), 1);
        chk("R6 toggle on match", int'(oc_out), 1);
        wr(7, 1); step(0); @(negedge clk);
        chk("R5 flag cleared", int'(match_flag), 0);

        // R9: counter written equal to compare hides the match
        wr16(0, 16'h1234);
        step(1); step(0); @(negedge clk);
        chk("R9 blocked flag", int'(match_flag), 0);
        chk("R9 blocked output", int'(oc_out), 1);

        // R8: force with clear action in free mode
        wr(6, 8'h18); step(0); @(negedge clk);
        chk("R8 forced output", int'(oc_out), 0);
        chk("R8 no flag", int'(match_flag), 0);
        rd16(0, v); chk("R8 counter untouched", v, 16'h1235);
        rd16(6, v); chk("R8 strobe reads zero", v & 8'h10, 0);

        // R10: PWM, counter written at the limit runs past it
        wr(6, 8'h0A);
        wr16(4, 5);
        wr16(0, 5);
        ticks(3);
        rd16(0, v); chk("R10 limit skipped", v, 8);
        wr16(0, 16'hFFFE);
        ticks(3);
        rd16(0, v); chk("R10 wrap through FFFF", v, 1);

        // R3/R4: buffered compare in PWM
        wr16(2, 3);
        rd16(2, v); chk("R4 shadow read in PWM", v, 3);
        wr(6, 8'h08);
        rd16(2, v); chk("R3 active unchanged", v, 16'h1234);
        wr(6, 8'h0A);
        ticks(5);
        wr(6, 8'h08);
        rd16(2, v); chk("R3 reload at rollover", v, 3);

        // R11: mode change alone keeps the output
        saved = oc_out;
        wr(6, 8'h09); step(0); @(negedge clk);
        chk("R11 mode change keeps output", int'(oc_out), int'(saved));

        // R7: PWM levels, small limit, both actions
        wr(6, 8'h0A); wr16(4, 6); wr16(2, 2); ticks(40);
        wr(6, 8'h0E); ticks(40);

        // Random phase: small values, frequent matches
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 70) step(1);
            else if (r < 76) step(0);
            else begin
                int a, d;
                a = $urandom_range(0, 7);
                d = a[0] ? ($urandom_range(0, 9) == 0 ? $urandom_range(0, 255) : 0)
                         : $urandom_range(0, 15);
                if (a == 6) d = $urandom_range(0, 31);
                if (a == 7) d = $urandom_range(0, 1);
                wr(a, d);
            end
        end
        step(0); step(0);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule